// File: doc/BRIEF.md
# Dock Flag and Predicate Unit

This block holds the three condition flags of an instruction-executing dock: two general-purpose flags, A and B, and a control flag, C. Every instruction carries a 3-bit condition code. The unit evaluates that code against the flags and reports whether the instruction should take effect. The flag-update instruction carries one 6-bit mask for A and one for B. Each mask picks any set of the literals A, not A, B, not B, C and not C. The flag becomes the OR of the picked literals. An empty mask therefore clears the flag. A mask that picks a flag together with its complement sets it. A mask that picks only the flag itself leaves it unchanged.

Software has no direct write path to C. C is loaded from a side input each time the dock's data latch captures a new value. At an output dock that input is a status bit from the attached unit. At an input dock it is a spare address bit of the arriving packet. The instruction decoder drives the condition code and the update strobe. The datapath drives the latch-load strobe. All outputs are registered, and the unit uses a synchronous active-high reset.

Top module: `flag_pred_unit`

## Requirements
- R1: While `rst` is high at a clock edge, A, B, C and `pred_ok` are all 0 after that edge.
- R2: `pred_ok` after an edge is the condition `pred_code` sampled at that edge, evaluated on the flags held before that edge, with this encoding: 000 A is 1, 001 A is 0, 010 B is 1, 011 B is 0, 100 C is 1, 101 C is 0.
- R3: Code 110 gives `pred_ok` 0 and code 111 gives `pred_ok` 1, whatever the flags hold.
- R4: When `upd_en` is high, the new A is the OR of the literals selected by `upd_mask_a`, and the new B is the same function of `upd_mask_b`. The mask bit positions are bit0 A, bit1 not A, bit2 B, bit3 not B, bit4 C, bit5 not C.
- R5: An all-zero mask writes 0. A mask that selects a flag and its complement writes 1.
- R6: Both new values are computed from the flags held before the edge. A mask of 000100 for A and 000001 for B swaps A and B in one cycle.
- R7: A mask that selects only the flag being written (000001 for A, 000100 for B) leaves that flag unchanged.
- R8: When `ld_en` is high, C takes `ld_c` at that edge, whether or not `upd_en` is also high.
- R9: C changes only on a cycle with `ld_en` high. `upd_en` and the masks never alter it.
- R10: When `upd_en` is low, A and B hold their values and the masks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_code | input | 3 | Condition code of the instruction being evaluated |
| upd_en | input | 1 | Strobe for the flag-update instruction |
| upd_mask_a | input | 6 | Literal-select mask for the new A |
| upd_mask_b | input | 6 | Literal-select mask for the new B |
| ld_en | input | 1 | Data latch captures a new value this cycle |
| ld_c | input | 1 | Control bit arriving with the latched value |
| pred_ok | output | 1 | Registered condition result |
| flag_a | output | 1 | Flag A |
| flag_b | output | 1 | Flag B |
| flag_c | output | 1 | Flag C |

## Verification
A corrupted flag shows up directly on its output one edge after it is written. It also shows up one edge later in `pred_ok`, for any condition code that tests that flag. Many update masks read the other flags, so a single wrong bit spreads into A or B on the next update. The random stream therefore catches a stale or cross-wired flag within a few cycles. Simultaneous swaps, empty masks, complement pairs and a load that coincides with an update are driven as directed cases, because random draws hit them rarely.

// File: rtl/flag_pkg.sv
package flag_pkg;
  // Flag count and derived widths
  localparam int unsigned NFLAG   = 3;
  localparam int unsigned LIT_W   = 2 * NFLAG;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned NPROG   = 2;   // programmable flags (A, B)
  // Flag indices in the flag vector
  localparam int unsigned IDX_A = 0;
  localparam int unsigned IDX_B = 1;
  localparam int unsigned IDX_C = 2;

  typedef logic [NFLAG-1:0] flag_vec_t;
  typedef logic [LIT_W-1:0] lit_vec_t;
endpackage

// File: rtl/flag_lit_or.sv
module flag_lit_or
  import flag_pkg::*;
#(
  parameter int unsigned N = NFLAG
) (
  input  logic [N-1:0]   cur,
  input  logic [2*N-1:0] sel,
  output logic           nxt
);
  logic [2*N-1:0] lits;

  // Even bit: flag true; odd bit: flag complement
  for (genvar i = 0; i < N; i++) begin : g_lit
    assign lits[2*i]   = cur[i];
    assign lits[2*i+1] = ~cur[i];
  end

  assign nxt = |(lits & sel);
endmodule

// File: rtl/flag_pred_eval.sv
module flag_pred_eval
  import flag_pkg::*;
#(
  parameter int unsigned N  = NFLAG,
  parameter int unsigned CW = CODE_W
) (
  input  logic [N-1:0]  cur,
  input  logic [CW-1:0] code,
  output logic          ok
);
  localparam int unsigned SEL_W = CW - 1;

  logic [SEL_W-1:0] which;
  logic             inv;

  assign which = code[CW-1:1];
  assign inv   = code[0];

  // Selector beyond the flag range: inv=0 never, inv=1 always
  always_comb begin
    if (32'(which) < N) ok = cur[which] ^ inv;
    else                ok = inv;
  end
endmodule

// File: rtl/flag_regs.sv
module flag_regs
  import flag_pkg::*;
#(
  parameter int unsigned N  = NFLAG,
  parameter int unsigned NP = NPROG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  logic [NP-1:0] upd_val,
  input  logic          ld_en,
  input  logic          ld_val,
  output logic [N-1:0]  flags
);
  // Programmable flags occupy the low indices
  for (genvar i = 0; i < NP; i++) begin : g_prog
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (upd_en) flags[i] <= upd_val[i];
    end
  end

  // Highest flag is loaded only by the data latch strobe
  always_ff @(posedge clk) begin
    if (rst)        flags[N-1] <= 1'b0;
    else if (ld_en) flags[N-1] <= ld_val;
  end
endmodule

// File: rtl/flag_pred_unit.sv
module flag_pred_unit
  import flag_pkg::*;
#(
  parameter int unsigned N  = NFLAG,
  parameter int unsigned CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] pred_code,
  input  logic          upd_en,
  input  logic [2*N-1:0] upd_mask_a,
  input  logic [2*N-1:0] upd_mask_b,
  input  logic          ld_en,
  input  logic          ld_c,
  output logic          pred_ok,
  output logic          flag_a,
  output logic          flag_b,
  output logic          flag_c
);
  localparam int unsigned NP = NPROG;

  logic [N-1:0]     flags;
  logic [2*N-1:0]   masks [NP];
  logic [NP-1:0]    nxt;
  logic             ok_c;

  assign masks[0] = upd_mask_a;
  assign masks[1] = upd_mask_b;

  // One OR-of-literals network per programmable flag, all on old flags
  for (genvar p = 0; p < NP; p++) begin : g_upd
    flag_lit_or #(.N(N)) u_or (
      .cur (flags),
      .sel (masks[p]),
      .nxt (nxt[p])
    );
  end

  flag_pred_eval #(.N(N), .CW(CW)) u_eval (
    .cur  (flags),
    .code (pred_code),
    .ok   (ok_c)
  );

  flag_regs #(.N(N), .NP(NP)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (upd_en),
    .upd_val (nxt),
    .ld_en   (ld_en),
    .ld_val  (ld_c),
    .flags   (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) pred_ok <= 1'b0;
    else     pred_ok <= ok_c;
  end

  assign flag_a = flags[IDX_A];
  assign flag_b = flags[IDX_B];
  assign flag_c = flags[IDX_C];
endmodule

// File: rtl/flag_pred_unit_chk.sv
module flag_pred_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] pred_code,
  input logic       upd_en,
  input logic [5:0] upd_mask_a,
  input logic [5:0] upd_mask_b,
  input logic       ld_en,
  input logic       ld_c,
  input logic       pred_ok,
  input logic       flag_a,
  input logic       flag_b,
  input logic       flag_c
);
  logic [5:0] lits;
  assign lits = {~flag_c, flag_c, ~flag_b, flag_b, ~flag_a, flag_a};

  // R3: reserved code is false, code 111 true
  p_code_never_r3: assert property (@(posedge clk) disable iff (rst)
    (pred_code == 3'b110) |=> !pred_ok);
  p_code_always_r3: assert property (@(posedge clk) disable iff (rst)
    (pred_code == 3'b111) |=> pred_ok);

  // R2: A-set code tracks the pre-edge A value
  p_code_a_r2: assert property (@(posedge clk) disable iff (rst)
    (pred_code == 3'b000) |=> (pred_ok == $past(flag_a)));

  // R4 / R6: both updates use the old literals
  p_upd_a_r4: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (flag_a == |($past(lits) & $past(upd_mask_a))));
  p_upd_b_r6: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (flag_b == |($past(lits) & $past(upd_mask_b))));

  // R10: no update, A and B hold
  p_hold_ab_r10: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> ($stable(flag_a) && $stable(flag_b)));

  // R8: load strobe captures the control bit
  p_load_c_r8: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (flag_c == $past(ld_c)));

  // R9: C holds without a load
  p_hold_c_r9: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> $stable(flag_c));
endmodule

bind flag_pred_unit flag_pred_unit_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .pred_code  (pred_code),
  .upd_en     (upd_en),
  .upd_mask_a (upd_mask_a),
  .upd_mask_b (upd_mask_b),
  .ld_en      (ld_en),
  .ld_c       (ld_c),
  .pred_ok    (pred_ok),
  .flag_a     (flag_a),
  .flag_b     (flag_b),
  .flag_c     (flag_c)
);

// File: tb/flag_pred_unit_bench.sv
module flag_pred_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] pred_code;
  logic       upd_en;
  logic [5:0] upd_mask_a, upd_mask_b;
  logic       ld_en, ld_c;
  logic       pred_ok, flag_a, flag_b, flag_c;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Reference state kept by the bench
  logic m_a, m_b, m_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_pred_unit u_flag_pred_unit (
    .clk        (clk),
    .rst        (rst),
    .pred_code  (pred_code),
    .upd_en     (upd_en),
    .upd_mask_a (upd_mask_a),
    .upd_mask_b (upd_mask_b),
    .ld_en      (ld_en),
    .ld_c       (ld_c),
    .pred_ok    (pred_ok),
    .flag_a     (flag_a),
    .flag_b     (flag_b),
    .flag_c     (flag_c)
  );

  function automatic logic ref_pred(input logic [2:0] c, input logic a, input logic b, input logic cc);
    case (c)
      3'b000: return a;
      3'b001: return !a;
      3'b010: return b;
      3'b011: return !b;
      3'b100: return cc;
      3'b101: return !cc;
      3'b110: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic ref_mask(input logic [5:0] m, input logic a, input logic b, input logic cc);
    logic r;
    r = 1'b0;
    if (m[0]) r = r | a;
    if (m[1]) r = r | !a;
    if (m[2]) r = r | b;
    if (m[3]) r = r | !b;
    if (m[4]) r = r | cc;
    if (m[5]) r = r | !cc;
    return r;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply one cycle at a falling edge and compare after the next rising edge
  task automatic step(input logic [2:0] code, input logic ue, input logic [5:0] ma,
                      input logic [5:0] mb, input logic le, input logic lc, input string tag);
    logic e_ok, e_a, e_b, e_c;
    pred_code = code; upd_en = ue; upd_mask_a = ma; upd_mask_b = mb;
    ld_en = le; ld_c = lc;
    e_ok = ref_pred(code, m_a, m_b, m_c);
    e_a  = ue ? ref_mask(ma, m_a, m_b, m_c) : m_a;
    e_b  = ue ? ref_mask(mb, m_a, m_b, m_c) : m_b;
    e_c  = le ? lc : m_c;
    @(posedge clk);
    @(negedge clk);
    m_a = e_a; m_b = e_b; m_c = e_c;
    check({tag, " pred"}, pred_ok, e_ok);
    check({tag, " A"},    flag_a,  e_a);
    check({tag, " B"},    flag_b,  e_b);
    check({tag, " C"},    flag_c,  e_c);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1357;
    void'($urandom(seed));
    rst = 1'b1; pred_code = 3'b111; upd_en = 1'b1; upd_mask_a = 6'h3f;
    upd_mask_b = 6'h3f; ld_en = 1'b1; ld_c = 1'b1;
    @(negedge clk); @(negedge clk);
    // R1: reset clears everything despite active strobes
    check("R1 pred", pred_ok, 1'b0);
    check("R1 A", flag_a, 1'b0);
    check("R1 B", flag_b, 1'b0);
    check("R1 C", flag_c, 1'b0);
    rst = 1'b0;
    m_a = 1'b0; m_b = 1'b0; m_c = 1'b0;

    // R5: complement pair sets A; R5 empty mask keeps B at 0
    step(3'b000, 1'b1, 6'b000011, 6'b000000, 1'b0, 1'b0, "R5");
    // R2: A-set code sees A=1; R6 swap A and B
    step(3'b000, 1'b1, 6'b000100, 6'b000001, 1'b0, 1'b0, "R6");
    // R7: self-select no-op on both
    step(3'b011, 1'b1, 6'b000001, 6'b000100, 1'b0, 1'b0, "R7");
    // R8: load with concurrent update; R9 masks cannot reach C
    step(3'b110, 1'b1, 6'b110000, 6'b100000, 1'b1, 1'b1, "R8");
    step(3'b100, 1'b1, 6'b000000, 6'b111111, 1'b0, 1'b0, "R9");
    // R10: masks ignored without the update strobe
    step(3'b101, 1'b0, 6'b111111, 6'b000000, 1'b0, 1'b0, "R10");
    // R3: reserved and always codes
    step(3'b110, 1'b0, 6'b0, 6'b0, 1'b0, 1'b0, "R3");
    step(3'b111, 1'b0, 6'b0, 6'b0, 1'b1, 1'b0, "R3");
    // R2: sweep every code with the flags held fixed
    for (int c = 0; c < 8; c++)
      step(3'(c), 1'b0, 6'b0, 6'b0, 1'b0, 1'b0, "R2");

    // R4: random mix of codes, updates and loads
    for (int i = 0; i < 600; i++) begin
      step(3'($urandom_range(7)), 1'($urandom_range(1)), 6'($urandom_range(63)),
           6'($urandom_range(63)), 1'($urandom_range(1)), 1'($urandom_range(1)), "R4");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule